// File: doc/BRIEF.md
# Nested Four-Level Interrupt Priority Controller

This block decides which of fifteen interrupt sources a processor core should take next. Every source carries its own enable and a two-bit priority made of a high and a low priority bit, giving four levels (0 lowest, 3 highest). A global enable gates all sources. The controller remembers which levels are currently being serviced, so a pending request is offered to the core only when its level is strictly above the highest level in service. Requests are evaluated only when the core signals the start of an instruction. The highest pending level wins, and among sources of equal level the lowest source index wins.

Two external pins feed two of the sources. Each pin can be used in level mode, where the request is present while the sampled pin is LOW, or in edge mode, where a HIGH sample followed by a LOW sample one cycle later latches a request flag. The core answers an offered request with an acknowledge pulse, which records the granted level as in service and clears the flag of an edge-mode pin source. The core sends a return pulse when a handler ends, which retires the highest level in service. Vector addresses and instruction fetch are the concern of the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `vec_o` is 0 and no level is in service, so the first request of any level, including level 0, can be offered.
- R2: While `glb_en_i` is 0 no request is offered, whatever the per-source enables and requests.
- R3: A source whose bit in `src_en_i` is 0 is never offered, even when it is requesting.
- R4: A source's level is `{prio_hi_i[i], prio_lo_i[i]}`; among the eligible requests the one with the highest level is offered.
- R5: Among eligible requests of equal level, the source with the lowest index is offered.
- R6: Requests are evaluated only in a cycle with `inst_start_i` high; `irq_o` and `vec_o` take the result on the following clock edge and hold until the next evaluation or an acknowledge. An acknowledge clears `irq_o` on the next edge and takes precedence over an evaluation in the same cycle.
- R7: While any level is in service, a request is offered only if its level is strictly greater than the highest level in service.
- R8: While level 3 is in service, no request is offered.
- R9: An acknowledge while `irq_o` is 1 marks the offered level as in service; a return pulse (`reti_i`) removes only the highest level in service, leaving lower ones in place.
- R10: With `ext_edge_i[k]` at 1, a sampled HIGH followed by a sampled LOW on the next cycle sets the pin's request flag; the flag stays set while the pin stays LOW and is cleared by the acknowledge of that source; a pin held LOW does not set it again.
- R11: With `ext_edge_i[k]` at 0, the pin's request is present exactly while the sampled pin is LOW, with nothing latched.
- R12: When a new falling edge is detected in the same cycle as the acknowledge of that pin's source, the flag remains set.
- R13: When an acknowledge and a return pulse fall in the same cycle, the return retires the highest level in service before the acknowledge marks the granted level.
- R14: Pin 0 drives source `EXT0_SRC` (default 0) and pin 1 drives source `EXT1_SRC` (default 2); such a source requests when either its `src_req_i` bit or its pin request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global interrupt enable |
| src_en_i | input | 15 | Per-source enable |
| prio_lo_i | input | 15 | Low priority bit per source |
| prio_hi_i | input | 15 | High priority bit per source |
| src_req_i | input | 15 | Internal request lines, active high |
| ext_pin_i | input | 2 | External interrupt pins |
| ext_edge_i | input | 2 | Per pin: 1 edge mode, 0 level mode |
| inst_start_i | input | 1 | Instruction-start pulse, triggers evaluation |
| ack_i | input | 1 | Core accepts the offered request |
| reti_i | input | 1 | Handler return pulse |
| irq_o | output | 1 | Request offered to the core |
| vec_o | output | 4 | Index of the offered source |

## Verification
Two pairs of events can coincide and are each driven deliberately into one cycle. A fresh falling edge on a pin is timed to be detected in the exact cycle its source is acknowledged; the outcome is judged by returning from the handler and evaluating again, where the request must still be offered. An acknowledge and a return pulse are issued together while level 1 is in service and level 2 is being granted; afterwards a second level-2 request must be refused and a level-3 request accepted, which only holds if the return was applied to the old in-service set before the grant.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  localparam int NEXT  = 2;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [NLVL-1:0]  svc_mask_t;
endpackage

// File: rtl/irqx_pin_detect.sv
module irqx_pin_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic req_o
);
  logic pin_q, pin_qq, flag;
  logic fall;

  assign fall = pin_qq & ~pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b1;
      pin_qq <= 1'b1;
      flag   <= 1'b0;
    end else begin
      pin_q  <= pin_i;
      pin_qq <= pin_q;
      if (!edge_mode_i)
        flag <= 1'b0;
      else if (fall)
        flag <= 1'b1;
      else if (clr_i)
        flag <= 1'b0;
    end
  end

  assign req_o = edge_mode_i ? flag : ~pin_q;

  // R10: a latched edge request survives until acknowledged
  p_edge_keep_r10: assert property (@(posedge clk) disable iff (rst)
    (edge_mode_i && flag && !clr_i) |=> flag);

  // R11: level mode mirrors the pin sampled one edge earlier
  p_level_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (!edge_mode_i) |=> (edge_mode_i || (req_o == !$past(pin_i))));
endmodule

// File: rtl/irqx_prio_arb.sv
module irqx_prio_arb
  import irqx_pkg::*;
#(
  parameter int NSRC  = 15,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]            pend_i,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl_i,
  output logic                       found_o,
  output logic [IDX_W-1:0]           idx_o,
  output lvl_t                       lvl_o
);
  // per-level pending masks
  logic [NLVL-1:0][NSRC-1:0] at_lvl;

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign at_lvl[l][i] = pend_i[i] && (lvl_i[i] == LVL_W'(l));
    end
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    // ascending levels, descending index: last hit is highest level, lowest index
    for (int l = 0; l < NLVL; l++) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (at_lvl[l][i]) begin
          found_o = 1'b1;
          idx_o   = IDX_W'(i);
          lvl_o   = LVL_W'(l);
        end
      end
    end
  end
endmodule

// File: rtl/irqx_svc_track.sv
module irqx_svc_track
  import irqx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  lvl_t set_lvl_i,
  input  logic reti_i,
  output logic svc_any_o,
  output lvl_t svc_top_o
);
  svc_mask_t mask, mask_nxt;

  always_comb begin
    svc_top_o = '0;
    for (int l = 0; l < NLVL; l++)
      if (mask[l]) svc_top_o = LVL_W'(l);
  end

  assign svc_any_o = |mask;

  always_comb begin
    mask_nxt = mask;
    if (reti_i && svc_any_o) mask_nxt[svc_top_o] = 1'b0;
    if (set_i)               mask_nxt[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else     mask <= mask_nxt;
  end

  // R9: a lone return retires exactly one level
  p_reti_one_r9: assert property (@(posedge clk) disable iff (rst)
    (reti_i && !set_i && (mask != '0)) |=> ($countones(mask) == $countones($past(mask)) - 1));

  // R9: an acknowledge always leaves its level in service
  p_ack_marks_r9: assert property (@(posedge clk) disable iff (rst)
    set_i |=> mask[$past(set_lvl_i)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqx_pkg::*;
#(
  parameter int NSRC     = 15,
  parameter int IDX_W    = $clog2(NSRC),
  parameter int EXT0_SRC = 0,
  parameter int EXT1_SRC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             glb_en_i,
  input  logic [NSRC-1:0]  src_en_i,
  input  logic [NSRC-1:0]  prio_lo_i,
  input  logic [NSRC-1:0]  prio_hi_i,
  input  logic [NSRC-1:0]  src_req_i,
  input  logic [NEXT-1:0]  ext_pin_i,
  input  logic [NEXT-1:0]  ext_edge_i,
  input  logic             inst_start_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] vec_o
);
  logic [NEXT-1:0]            ext_req;
  logic [NSRC-1:0]            ext_ovl, pend;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic                       win_found, allow, svc_any, grant;
  logic [IDX_W-1:0]           win_idx;
  lvl_t                       win_lvl, lvl_q, svc_top;

  assign grant = ack_i && irq_o;

  for (genvar k = 0; k < NEXT; k++) begin : g_pin
    localparam int SRC = (k == 0) ? EXT0_SRC : EXT1_SRC;
    logic clr;
    assign clr = grant && (vec_o == IDX_W'(SRC));
    irqx_pin_detect u_pin (
      .clk        (clk),
      .rst        (rst),
      .pin_i      (ext_pin_i[k]),
      .edge_mode_i(ext_edge_i[k]),
      .clr_i      (clr),
      .req_o      (ext_req[k])
    );
  end

  always_comb begin
    ext_ovl           = '0;
    ext_ovl[EXT0_SRC] = ext_req[0];
    ext_ovl[EXT1_SRC] = ext_ovl[EXT1_SRC] | ext_req[1];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign src_lvl[i] = {prio_hi_i[i], prio_lo_i[i]};
  end

  assign pend = (src_req_i | ext_ovl) & src_en_i & {NSRC{glb_en_i}};

  irqx_prio_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .pend_i (pend),
    .lvl_i  (src_lvl),
    .found_o(win_found),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  irqx_svc_track u_svc (
    .clk      (clk),
    .rst      (rst),
    .set_i    (grant),
    .set_lvl_i(lvl_q),
    .reti_i   (reti_i),
    .svc_any_o(svc_any),
    .svc_top_o(svc_top)
  );

  assign allow = win_found && (!svc_any || (win_lvl > svc_top));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      vec_o <= '0;
      lvl_q <= '0;
    end else if (ack_i) begin
      irq_o <= 1'b0;
    end else if (inst_start_i) begin
      irq_o <= allow;
      if (allow) begin
        vec_o <= win_idx;
        lvl_q <= win_lvl;
      end
    end
  end

  // R6: outputs only move on evaluation or acknowledge
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!inst_start_i && !ack_i) |=> ($stable(irq_o) && $stable(vec_o)));

  // R6: acknowledge withdraws the offer
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !irq_o);

  // R2: global enable low blocks any new offer
  p_glb_off_r2: assert property (@(posedge clk) disable iff (rst)
    (inst_start_i && !ack_i && !glb_en_i) |=> !irq_o);

  // R8: top level in service blocks every source
  p_top_block_r8: assert property (@(posedge clk) disable iff (rst)
    (inst_start_i && !ack_i && svc_any && (svc_top == lvl_t'(NLVL - 1))) |=> !irq_o);

  // R7: an offer made while busy is strictly above the busy level
  p_preempt_r7: assert property (@(posedge clk) disable iff (rst)
    (inst_start_i && !ack_i && svc_any) |=> (!irq_o || (lvl_q > $past(svc_top))));
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 15;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst;
  logic glb_en;
  logic [NSRC-1:0] src_en, prio_lo, prio_hi, src_req;
  logic [1:0] ext_pin, ext_edge;
  logic inst_start, ack, reti;
  logic irq;
  logic [3:0] vec;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .glb_en_i(glb_en), .src_en_i(src_en),
    .prio_lo_i(prio_lo), .prio_hi_i(prio_hi), .src_req_i(src_req),
    .ext_pin_i(ext_pin), .ext_edge_i(ext_edge), .inst_start_i(inst_start),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input bit e_irq, input int e_vec);
    chk({tag, " irq"}, int'(irq), int'(e_irq));
    if (e_irq) chk({tag, " vec"}, int'(vec), e_vec);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; glb_en = 1'b1; src_en = '0; prio_lo = '0; prio_hi = '0;
    src_req = '0; ext_pin = 2'b11; ext_edge = 2'b00;
    inst_start = 1'b0; ack = 1'b0; reti = 1'b0;
    wait_cyc(2);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_src(input int i, input bit en, input int lvl, input bit req);
    src_en[i] = en; prio_lo[i] = lvl[0]; prio_hi[i] = lvl[1]; src_req[i] = req;
  endtask

  task automatic pulse_start();
    inst_start = 1'b1; @(negedge clk); inst_start = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; @(negedge clk); reti = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_out("R1 after reset", 1'b0, 0);
    chk("R1 vec after reset", int'(vec), 0);
    set_src(13, 1, 0, 1);
    pulse_start();
    chk_out("R1 level 0 accepted when idle", 1'b1, 13);
  endtask

  task automatic t_global();
    do_reset();
    set_src(6, 1, 2, 1);
    glb_en = 1'b0;
    pulse_start();
    chk_out("R2 global disabled", 1'b0, 0);
    glb_en = 1'b1;
    pulse_start();
    chk_out("R2 global enabled", 1'b1, 6);
  endtask

  task automatic t_enable();
    do_reset();
    set_src(4, 0, 3, 1);
    pulse_start();
    chk_out("R3 disabled source", 1'b0, 0);
    set_src(10, 1, 0, 1);
    pulse_start();
    chk_out("R3 enabled lower source wins", 1'b1, 10);
  endtask

  task automatic t_level_wins();
    do_reset();
    set_src(1, 1, 1, 1); set_src(9, 1, 3, 1); set_src(3, 1, 2, 1);
    pulse_start();
    chk_out("R4 level 3 wins", 1'b1, 9);
    src_req[9] = 1'b0;
    pulse_start();
    chk_out("R4 level 2 wins next", 1'b1, 3);
  endtask

  task automatic t_tie();
    do_reset();
    set_src(12, 1, 2, 1); set_src(8, 1, 2, 1); set_src(11, 1, 2, 1);
    pulse_start();
    chk_out("R5 lowest index among equals", 1'b1, 8);
    src_req[8] = 1'b0;
    pulse_start();
    chk_out("R5 next lowest index", 1'b1, 11);
  endtask

  task automatic t_start_only();
    do_reset();
    set_src(5, 1, 1, 1);
    wait_cyc(4);
    chk_out("R6 no evaluation without start", 1'b0, 0);
    pulse_start();
    chk_out("R6 evaluated on start", 1'b1, 5);
    src_req[5] = 1'b0;
    wait_cyc(3);
    chk_out("R6 offer held between starts", 1'b1, 5);
    src_req[5] = 1'b1;
    inst_start = 1'b1; ack = 1'b1;
    @(negedge clk);
    inst_start = 1'b0; ack = 1'b0;
    chk_out("R6 ack beats start", 1'b0, 0);
  endtask

  task automatic t_preempt();
    do_reset();
    set_src(3, 1, 1, 1);
    pulse_start(); pulse_ack();
    set_src(3, 1, 1, 0);
    set_src(1, 1, 1, 1); set_src(0, 1, 0, 1);
    pulse_start();
    chk_out("R7 equal or lower level refused", 1'b0, 0);
    set_src(14, 1, 2, 1);
    pulse_start();
    chk_out("R7 higher level preempts", 1'b1, 14);
  endtask

  task automatic t_top();
    do_reset();
    set_src(7, 1, 3, 1);
    pulse_start(); pulse_ack();
    set_src(2, 1, 3, 1);
    pulse_start();
    chk_out("R8 level 3 in service blocks all", 1'b0, 0);
    pulse_reti();
    pulse_start();
    chk_out("R8 after return level 3 accepted", 1'b1, 2);
  endtask

  task automatic t_reti();
    do_reset();
    set_src(11, 1, 0, 1);
    pulse_start(); pulse_ack();
    set_src(11, 1, 0, 0);
    set_src(12, 1, 2, 1);
    pulse_start(); pulse_ack();
    set_src(12, 1, 2, 0);
    set_src(13, 1, 1, 1);
    pulse_start();
    chk_out("R9 level 1 refused under level 2", 1'b0, 0);
    pulse_reti();
    pulse_start();
    chk_out("R9 return keeps level 0, level 1 offered", 1'b1, 13);
    set_src(13, 1, 1, 0);
    set_src(14, 1, 0, 1);
    pulse_start();
    chk_out("R9 level 0 still in service", 1'b0, 0);
  endtask

  task automatic t_edge();
    do_reset();
    ext_edge = 2'b01;
    set_src(0, 1, 1, 0);
    wait_cyc(3);
    pulse_start();
    chk_out("R10 no edge no request", 1'b0, 0);
    ext_pin[0] = 1'b0;
    wait_cyc(3);
    pulse_start();
    chk_out("R10 falling edge latched", 1'b1, 0);
    pulse_ack(); pulse_reti();
    wait_cyc(2);
    pulse_start();
    chk_out("R10 flag cleared by ack, low pin no retrigger", 1'b0, 0);
  endtask

  task automatic t_level_pin();
    do_reset();
    set_src(0, 1, 2, 0);
    ext_pin[0] = 1'b0;
    wait_cyc(2);
    pulse_start();
    chk_out("R11 low pin requests", 1'b1, 0);
    ext_pin[0] = 1'b1;
    wait_cyc(2);
    pulse_start();
    chk_out("R11 request gone with pin high", 1'b0, 0);
  endtask

  task automatic t_ext_or();
    do_reset();
    set_src(2, 1, 1, 1);
    pulse_start();
    chk_out("R14 internal line of pin source", 1'b1, 2);
    src_req[2] = 1'b0;
    ext_pin[1] = 1'b0;
    wait_cyc(2);
    pulse_start();
    chk_out("R14 pin 1 drives source 2", 1'b1, 2);
  endtask

  task automatic t_edge_ack();
    do_reset();
    ext_edge = 2'b01;
    set_src(0, 1, 1, 0);
    ext_pin[0] = 1'b0;
    wait_cyc(3);
    pulse_start();
    chk_out("R12 first edge offered", 1'b1, 0);
    ext_pin[0] = 1'b1;
    wait_cyc(2);
    ext_pin[0] = 1'b0;
    @(negedge clk);
    pulse_ack();
    pulse_reti();
    pulse_start();
    chk_out("R12 edge during ack kept", 1'b1, 0);
  endtask

  task automatic t_ack_reti();
    do_reset();
    set_src(5, 1, 1, 1);
    pulse_start(); pulse_ack();
    set_src(5, 1, 1, 0);
    set_src(6, 1, 2, 1);
    pulse_start();
    chk_out("R13 level 2 preempts level 1", 1'b1, 6);
    ack = 1'b1; reti = 1'b1;
    @(negedge clk);
    ack = 1'b0; reti = 1'b0;
    pulse_start();
    chk_out("R13 level 2 now in service, level 2 refused", 1'b0, 0);
    set_src(7, 1, 3, 1);
    pulse_start();
    chk_out("R13 level 3 accepted", 1'b1, 7);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_global();
    t_enable();
    t_level_wins();
    t_tie();
    t_start_only();
    t_preempt();
    t_top();
    t_reti();
    t_edge();
    t_level_pin();
    t_ext_or();
    t_edge_ack();
    t_ack_reti();
    report();
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
    report();
  end
endmodule